// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a small shared word memory and serves several processor ports at once. Each port can issue a plain load, a plain store, a load-linked or a store-conditional every cycle. A load-linked returns the word and arms a reservation for that port: one valid bit and one address. A store-conditional writes the memory only if the issuing port still holds an armed reservation on the same address. It reports success (1) or failure (0).

The monitor watches every write that reaches the memory, from plain stores and from successful store-conditionals alike. When another port writes a reserved address, that reservation is dropped. A failed store-conditional changes nothing outside its own port, so software can build spin locks and atomic updates by retrying a load-linked / store-conditional pair. All responses are registered and arrive one cycle after the request. Reads see the memory as it was before the writes of the same cycle.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (op code 2'b10) returns the addressed word on `rsp_rdata_o` one cycle later and arms a reservation for that port on that address.
- R2: A store-conditional (op code 2'b11) from a port whose armed reservation matches its address writes its data to memory, provided no conflicting write occurs in the same cycle.
- R3: `rsp_sc_ok_o` of a port is 1 one cycle after a successful store-conditional, and 0 after a failed one or after any other operation.
- R4: A failing store-conditional leaves the memory unchanged and does not disturb the reservations of other ports.
- R5: Every store-conditional, successful or not, disarms the issuing port's reservation, so a second store-conditional without a new load-linked fails.
- R6: Each port holds one reservation; a new load-linked replaces the previous one, and a store-conditional to the old address then fails.
- R7: A write to a reserved address by any other port (plain store or successful store-conditional) disarms that reservation; a plain store by the holding port itself does not.
- R8: A store-conditional to an address other than the reserved one fails.
- R9: When several ports issue store-conditionals to the same reserved address in one cycle, only the lowest-numbered eligible port succeeds, and the others lose their reservations.
- R10: A plain store (2'b01) writes the word; a plain load (2'b00) returns it one cycle later; reads return the value from before same-cycle writes; for same-cycle plain stores to one address the lowest-numbered port's data is kept. Responses to stores and store-conditionals carry read data 0.
- R11: After reset no response is valid, every reservation is disarmed and every memory word is 0.
- R12: A load-linked that meets a same-cycle write by another port to its address returns the old word but arms no reservation. A store-conditional that meets a same-cycle plain store by another port to its address fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | NUM_PORTS | Per-port request valid |
| req_op_i | input | 2*NUM_PORTS | Per-port op code: 00 load, 01 store, 10 load-linked, 11 store-conditional |
| req_addr_i | input | ADDR_W*NUM_PORTS | Per-port word address |
| req_wdata_i | input | DATA_W*NUM_PORTS | Per-port write data |
| rsp_valid_o | output | NUM_PORTS | Per-port response valid, one cycle after request |
| rsp_rdata_o | output | DATA_W*NUM_PORTS | Read data for loads and load-linked, else 0 |
| rsp_sc_ok_o | output | NUM_PORTS | Store-conditional success flag |

## Verification
The core pair is exercised under several patterns. A clean load-linked / store-conditional pair must succeed. A repeated store-conditional, a store-conditional after a replacing load-linked, and one to a mismatched address must each fail, which separates a correct disarm rule from a monitor that only compares addresses. An intervening store from another port is set against one from the owning port, and a failed store-conditional by a port without a reservation is checked against a neighbour's still-armed one; these pairs tell snoop clearing apart from over-eager clearing. Same-cycle collisions cover racing store-conditionals, a store-conditional against a plain store, a load-linked against a store, and competing plain stores. They show whether priority and read-before-write ordering are resolved as specified.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LL    = 2'b10,
    OP_SC    = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] is_st_i,
  input  logic [NUM_PORTS-1:0] is_sc_i,
  input  logic [ADDR_W-1:0]    addr_i  [NUM_PORTS],
  input  logic [NUM_PORTS-1:0] res_v_i,
  input  logic [ADDR_W-1:0]    res_a_i [NUM_PORTS],
  output logic [NUM_PORTS-1:0] sc_ok_o,
  output logic [NUM_PORTS-1:0] wr_en_o
);
  logic [NUM_PORTS-1:0] st_conflict;

  always_comb begin
    st_conflict = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int q = 0; q < NUM_PORTS; q++) begin
        if (q != p && is_st_i[q] && addr_i[q] == addr_i[p]) st_conflict[p] = 1'b1;
      end
    end
  end

  // lower ports resolved first; each sees only lower winners
  always_comb begin
    sc_ok_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      logic lower_win;
      lower_win = 1'b0;
      for (int q = 0; q < p; q++) begin
        if (sc_ok_o[q] && addr_i[q] == addr_i[p]) lower_win = 1'b1;
      end
      sc_ok_o[p] = is_sc_i[p] && res_v_i[p] && (res_a_i[p] == addr_i[p])
                   && !st_conflict[p] && !lower_win;
    end
  end

  assign wr_en_o = is_st_i | sc_ok_o;

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_pi
      for (genvar j = i + 1; j < NUM_PORTS; j++) begin : g_pj
        // R9: never two winners on one address
        a_r9_single_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
          !(sc_ok_o[i] && sc_ok_o[j] && addr_i[i] == addr_i[j]));
      end
    end
  endgenerate
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 4,
  parameter int PORT_ID   = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 is_ll_i,
  input  logic                 is_sc_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_PORTS-1:0] wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i [NUM_PORTS],
  output logic                 res_v_o,
  output logic [ADDR_W-1:0]    res_a_o
);
  logic kill, ll_hit;

  always_comb begin
    kill   = 1'b0;
    ll_hit = 1'b0;
    for (int q = 0; q < NUM_PORTS; q++) begin
      if (q != PORT_ID && wr_en_i[q]) begin
        if (wr_addr_i[q] == res_a_o) kill   = 1'b1;
        if (wr_addr_i[q] == addr_i)  ll_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_v_o <= 1'b0;
      res_a_o <= '0;
    end else if (is_ll_i) begin
      res_v_o <= !ll_hit;
      res_a_o <= addr_i;
    end else if (is_sc_i || kill) begin
      res_v_o <= 1'b0;
    end
  end

  a_r1_ll_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ll_i && !ll_hit |=> res_v_o && res_a_o == $past(addr_i));
  a_r5_sc_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sc_i |=> !res_v_o);
  a_r7_snoop_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_v_o && kill && !is_ll_i |=> !res_v_o);
  a_r12_ll_race_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ll_i && ll_hit |=> !res_v_o);
endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i  [NUM_PORTS],
  input  logic [NUM_PORTS-1:0] wr_en_i,
  input  logic [DATA_W-1:0]    wdata_i [NUM_PORTS],
  output logic [DATA_W-1:0]    rdata_o [NUM_PORTS]
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) rdata_o[p] = mem_q[addr_i[p]];
  end

  // highest index first so lowest port's write lands last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else begin
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
        if (wr_en_i[p]) mem_q[addr_i[p]] <= wdata_i[p];
      end
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_PORTS-1:0]          req_valid_i,
  input  logic [2*NUM_PORTS-1:0]        req_op_i,
  input  logic [ADDR_W*NUM_PORTS-1:0]   req_addr_i,
  input  logic [DATA_W*NUM_PORTS-1:0]   req_wdata_i,
  output logic [NUM_PORTS-1:0]          rsp_valid_o,
  output logic [DATA_W*NUM_PORTS-1:0]   rsp_rdata_o,
  output logic [NUM_PORTS-1:0]          rsp_sc_ok_o
);
  logic [ADDR_W-1:0]    addr  [NUM_PORTS];
  logic [DATA_W-1:0]    wdata [NUM_PORTS];
  logic [DATA_W-1:0]    rdata [NUM_PORTS];
  logic [ADDR_W-1:0]    res_a [NUM_PORTS];
  llsc_op_e             op    [NUM_PORTS];
  logic [NUM_PORTS-1:0] is_ld, is_st, is_ll, is_sc, res_v, sc_ok, wr_en;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign op[p]    = llsc_op_e'(req_op_i[2*p +: 2]);
      assign addr[p]  = req_addr_i[ADDR_W*p +: ADDR_W];
      assign wdata[p] = req_wdata_i[DATA_W*p +: DATA_W];
      assign is_ld[p] = req_valid_i[p] && op[p] == OP_LOAD;
      assign is_st[p] = req_valid_i[p] && op[p] == OP_STORE;
      assign is_ll[p] = req_valid_i[p] && op[p] == OP_LL;
      assign is_sc[p] = req_valid_i[p] && op[p] == OP_SC;

      llsc_resv #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .PORT_ID(p)) u_resv (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .is_ll_i   (is_ll[p]),
        .is_sc_i   (is_sc[p]),
        .addr_i    (addr[p]),
        .wr_en_i   (wr_en),
        .wr_addr_i (addr),
        .res_v_o   (res_v[p]),
        .res_a_o   (res_a[p])
      );

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          rsp_valid_o[p]                 <= 1'b0;
          rsp_sc_ok_o[p]                 <= 1'b0;
          rsp_rdata_o[DATA_W*p +: DATA_W] <= '0;
        end else begin
          rsp_valid_o[p]                 <= req_valid_i[p];
          rsp_sc_ok_o[p]                 <= sc_ok[p];
          rsp_rdata_o[DATA_W*p +: DATA_W] <= (is_ld[p] || is_ll[p]) ? rdata[p] : '0;
        end
      end

      a_r3_ok_only_after_sc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_valid_i[p] && op[p] == OP_SC) |=> !rsp_sc_ok_o[p]);
    end
  endgenerate

  llsc_arbiter #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .is_st_i (is_st),
    .is_sc_i (is_sc),
    .addr_i  (addr),
    .res_v_i (res_v),
    .res_a_i (res_a),
    .sc_ok_o (sc_ok),
    .wr_en_o (wr_en)
  );

  llsc_mem #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr),
    .wr_en_i (wr_en),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );
endmodule

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
  localparam int N  = 3;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op    = '0;
  logic [AW*N-1:0] req_addr  = '0;
  logic [DW*N-1:0] req_wdata = '0;
  logic [N-1:0]    rsp_valid, rsp_ok;
  logic [DW*N-1:0] rsp_rdata;
  int checks = 0, failures = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  llsc_monitor #(.NUM_PORTS(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .rsp_sc_ok_o(rsp_ok));

  typedef struct packed {
    logic [1:0]  port;
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [15:0] wd;
    logic        ok;
    logic [15:0] rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{2'd0, ST, 4'd3, 16'h1111, 1'b0, 16'h0000, 4'd10}, // R10 store
    '{2'd0, LD, 4'd3, 16'h0000, 1'b0, 16'h1111, 4'd10}, // R10 load
    '{2'd0, LL, 4'd3, 16'h0000, 1'b0, 16'h1111, 4'd1},  // R1
    '{2'd0, SC, 4'd3, 16'h2222, 1'b1, 16'h0000, 4'd2},  // R2
    '{2'd0, LD, 4'd3, 16'h0000, 1'b0, 16'h2222, 4'd2},  // R2 data landed
    '{2'd0, SC, 4'd3, 16'h3333, 1'b0, 16'h0000, 4'd5},  // R5 repeat fails
    '{2'd0, LD, 4'd3, 16'h0000, 1'b0, 16'h2222, 4'd4},  // R4 no write
    '{2'd1, LL, 4'd5, 16'h0000, 1'b0, 16'h0000, 4'd1},  // R1
    '{2'd1, LL, 4'd6, 16'h0000, 1'b0, 16'h0000, 4'd6},  // R6 replace
    '{2'd1, SC, 4'd5, 16'h0004, 1'b0, 16'h0000, 4'd6},  // R6 old addr fails
    '{2'd1, LD, 4'd5, 16'h0000, 1'b0, 16'h0000, 4'd4},  // R4
    '{2'd2, LL, 4'd7, 16'h0000, 1'b0, 16'h0000, 4'd1},  // R1
    '{2'd2, SC, 4'd8, 16'h0005, 1'b0, 16'h0000, 4'd8},  // R8 mismatch
    '{2'd2, LD, 4'd8, 16'h0000, 1'b0, 16'h0000, 4'd8},  // R8 no write
    '{2'd0, LL, 4'd9, 16'h0000, 1'b0, 16'h0000, 4'd1},  // R1
    '{2'd1, ST, 4'd9, 16'h0077, 1'b0, 16'h0000, 4'd7},  // R7 foreign store
    '{2'd0, SC, 4'd9, 16'h0088, 1'b0, 16'h0000, 4'd7},  // R7 disarmed
    '{2'd0, LD, 4'd9, 16'h0000, 1'b0, 16'h0077, 4'd7},  // R7
    '{2'd0, LL, 4'd4, 16'h0000, 1'b0, 16'h0000, 4'd1},  // R1
    '{2'd0, ST, 4'd4, 16'h0012, 1'b0, 16'h0000, 4'd7},  // R7 own store
    '{2'd0, SC, 4'd4, 16'h0034, 1'b1, 16'h0000, 4'd7},  // R7 still armed
    '{2'd0, LD, 4'd4, 16'h0000, 1'b0, 16'h0034, 4'd3}   // R3
  };

  task automatic chk(input bit cond, input int r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic set_req(input int p, input logic [1:0] op, input logic [3:0] a,
                         input logic [15:0] d);
    req_valid[p]         = 1'b1;
    req_op[2*p +: 2]     = op;
    req_addr[AW*p +: AW] = a;
    req_wdata[DW*p +: DW] = d;
  endtask

  task automatic clear_req();
    req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
  endtask

  // inputs set at negedge; response checked at following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic [15:0] rd_of(input int p);
    return rsp_rdata[DW*p +: DW];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(rsp_valid == '0, 11, "rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    set_req(0, LD, 4'd3, 16'h0); step();
    chk(rd_of(0) == 16'h0, 11, "memory zero after reset", 32'(rd_of(0)), 0);
    clear_req();
    set_req(0, SC, 4'd3, 16'hbeef); step();
    chk(rsp_ok[0] == 1'b0, 11, "sc without reservation", 32'(rsp_ok[0]), 0);
    clear_req();

    for (int i = 0; i < NV; i++) begin
      int p;
      p = int'(VEC[i].port);
      set_req(p, VEC[i].op, VEC[i].addr, VEC[i].wd);
      step();
      chk(rsp_valid == (N'(1) << p), int'(VEC[i].req), $sformatf("vec%0d valid", i),
          32'(rsp_valid), 32'(N'(1) << p));
      chk(rsp_ok[p] == VEC[i].ok, int'(VEC[i].req), $sformatf("vec%0d sc_ok", i),
          32'(rsp_ok[p]), 32'(VEC[i].ok));
      chk(rd_of(p) == VEC[i].rd, int'(VEC[i].req), $sformatf("vec%0d rdata", i),
          32'(rd_of(p)), 32'(VEC[i].rd));
      clear_req();
    end

    // R9 racing store-conditionals
    set_req(0, LL, 4'd10, 0); set_req(1, LL, 4'd10, 0); set_req(2, LL, 4'd10, 0);
    step(); clear_req();
    set_req(1, SC, 4'd10, 16'haaaa); set_req(2, SC, 4'd10, 16'hbbbb);
    step();
    chk(rsp_ok[1] == 1'b1, 9, "low port wins", 32'(rsp_ok[1]), 1);
    chk(rsp_ok[2] == 1'b0, 9, "high port loses", 32'(rsp_ok[2]), 0);
    clear_req();
    set_req(0, SC, 4'd10, 16'hcccc); step();
    chk(rsp_ok[0] == 1'b0, 9, "third port lost reservation", 32'(rsp_ok[0]), 0);
    clear_req();
    set_req(0, LD, 4'd10, 0); step();
    chk(rd_of(0) == 16'haaaa, 9, "winner data", 32'(rd_of(0)), 32'haaaa);
    clear_req();

    // R4 failed SC keeps neighbour's reservation
    set_req(0, LL, 4'd11, 0); step(); clear_req();
    set_req(1, SC, 4'd11, 16'h0bad); step();
    chk(rsp_ok[1] == 1'b0, 4, "unreserved sc fails", 32'(rsp_ok[1]), 0);
    clear_req();
    set_req(0, SC, 4'd11, 16'h600d); step();
    chk(rsp_ok[0] == 1'b1, 4, "neighbour still armed", 32'(rsp_ok[0]), 1);
    clear_req();

    // R10 same-cycle stores and read-before-write
    set_req(0, ST, 4'd12, 16'h00a0); set_req(2, ST, 4'd12, 16'h00c2);
    set_req(1, LD, 4'd12, 0); step();
    chk(rd_of(1) == 16'h0, 10, "read sees old value", 32'(rd_of(1)), 0);
    clear_req();
    set_req(1, LD, 4'd12, 0); step();
    chk(rd_of(1) == 16'h00a0, 10, "lowest store kept", 32'(rd_of(1)), 32'h00a0);
    clear_req();

    // R12 load-linked racing a store
    set_req(1, ST, 4'd13, 16'h0013); set_req(0, LL, 4'd13, 0); step();
    chk(rd_of(0) == 16'h0, 12, "ll returns old word", 32'(rd_of(0)), 0);
    clear_req();
    set_req(0, SC, 4'd13, 16'h0099); step();
    chk(rsp_ok[0] == 1'b0, 12, "ll race unarmed", 32'(rsp_ok[0]), 0);
    clear_req();
    // R12 store-conditional racing a plain store
    set_req(0, LL, 4'd14, 0); step(); clear_req();
    set_req(0, SC, 4'd14, 16'h0001); set_req(2, ST, 4'd14, 16'h0002); step();
    chk(rsp_ok[0] == 1'b0, 12, "sc vs store fails", 32'(rsp_ok[0]), 0);
    clear_req();
    set_req(0, LD, 4'd14, 0); step();
    chk(rd_of(0) == 16'h0002, 12, "plain store kept", 32'(rd_of(0)), 32'h0002);
    clear_req();

    step();
    finish_run();
  end
endmodule